// File: doc/BRIEF.md
# ADC Output Formatter and Test Control

This block takes the corrected converter word and its below-range and above-range flags, and shapes them for the output pins. Two static controls invert bits of the word. One control inverts the top bit and the other inverts every bit beneath it. With these two controls the word can leave as straight binary, two's complement or one's complement.

An active-low test control replaces the live word with a fixed alternating pattern. That pattern still passes through both inversion controls. The formatted word and the flags are captured in one register stage. A registered enable tells the pad drivers when to float the pins.

While the standby input is high, the output registers hold their contents. After standby is released, a ready flag stays low for a fixed number of settling cycles. It also stays low for the same number of cycles after reset.

Top module: `adc_out_fmt`

## Requirements
- R1: While reset is active, and on the first cycle after it, `dout`, `under_out`, `over_out`, `out_en` and `ready` are all 0.
- R2: When `msb_inv` is 1, output bit 9 is the inverse of source bit 9. When it is 0, bit 9 is passed through unchanged.
- R3: When `low_inv` is 1, output bits 8..0 are the inverse of source bits 8..0. When it is 0, those bits are passed through unchanged. The control never affects bit 9.
- R4: Outputs are registered. A word accepted at a rising edge appears after that edge, and a new word can be accepted on every edge. When `valid_in` is 0 outside test mode, `dout` and both flags keep their previous values.
- R5: When `test_n` is 0, the source word is the fixed pattern 10'b1010101010, with bit 9 = 1 and bit 0 = 0. R2 and R3 are applied to it. It is loaded on every edge, whatever the value of `valid_in`.
- R6: The range flags are registered together with the word and are never changed by `msb_inv` or `low_inv`.
- R7: While `test_n` is 0, both range flags are loaded as 0.
- R8: `out_en` is the inverse of `hiz_req`, delayed by one clock edge.
- R9: While `standby` is 1, `dout` and both flags hold their values, and `ready` is 0 after the next edge.
- R10: `ready` rises after 4 consecutive edges at which `standby` is 0, counted after reset or after standby is released. Any edge with `standby` at 1 restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_in | input | 10 | Corrected converter word |
| under_in | input | 1 | Input below range |
| over_in | input | 1 | Input above range |
| valid_in | input | 1 | `code_in` and the flags are valid this cycle |
| msb_inv | input | 1 | Invert the top bit |
| low_inv | input | 1 | Invert the lower nine bits |
| test_n | input | 1 | Active-low test pattern select |
| hiz_req | input | 1 | Request to float the output pins |
| standby | input | 1 | Stop conversion and hold the outputs |
| dout | output | 10 | Formatted word |
| under_out | output | 1 | Registered below-range flag |
| over_out | output | 1 | Registered above-range flag |
| out_en | output | 1 | Pad driver enable |
| ready | output | 1 | Outputs are at rated accuracy |

## Verification
The situation hardest to reach from the ports is a standby pulse that arrives part-way through the settling count, because random standby traffic rarely lands inside the four-cycle window. Directed sequences therefore release standby for two cycles, pulse it for one cycle, and then release it again. The bench checks that `ready` stays low until four clean edges have passed. Random traffic keeps standby rare so that the count completes often. Between those completions, the traffic mixes test mode, invalid cycles and float requests under all four inversion settings.

// File: rtl/adc_out_fmt.sv
module adc_out_fmt #(
  parameter int W      = 10,
  parameter int SETTLE = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code_in,
  input  logic         under_in,
  input  logic         over_in,
  input  logic         valid_in,
  input  logic         msb_inv,
  input  logic         low_inv,
  input  logic         test_n,
  input  logic         hiz_req,
  input  logic         standby,
  output logic [W-1:0] dout,
  output logic         under_out,
  output logic         over_out,
  output logic         out_en,
  output logic         ready
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [W-1:0]  pat;
  logic [W-1:0]  src;
  logic [W-1:0]  fmt;
  logic          load;
  logic [CW-1:0] cnt;

  for (genvar g = 0; g < W; g++) begin : g_pat
    assign pat[g] = ((W - 1 - g) % 2) == 0;
  end

  assign src  = test_n ? code_in : pat;
  assign fmt  = {src[W-1] ^ msb_inv, src[W-2:0] ^ {(W-1){low_inv}}};
  assign load = !standby && (valid_in || !test_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout      <= '0;
      under_out <= 1'b0;
      over_out  <= 1'b0;
      out_en    <= 1'b0;
      cnt       <= '0;
    end else begin
      out_en <= !hiz_req;
      if (load) begin
        dout      <= fmt;
        under_out <= test_n & under_in;
        over_out  <= test_n & over_in;
      end
      if (standby)
        cnt <= '0;
      else if (cnt != CW'(SETTLE))
        cnt <= cnt + 1'b1;
    end
  end

  assign ready = (cnt == CW'(SETTLE));

  // R9
  stby_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !ready);
  // R9
  stby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> ($stable(dout) && $stable(under_out) && $stable(over_out)));
  // R7
  test_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_n && !standby) |=> (!under_out && !over_out));
  // R8
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_req |=> !out_en);
  // R8
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hiz_req |=> out_en);
  // R10
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> !$past(standby));
  // R4
  hold_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_in && test_n) |=> $stable(dout));
endmodule

// File: tb/adc_out_fmt_test.sv
module adc_out_fmt_test;
  localparam int W = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] code_in = '0;
  logic         under_in = 1'b0, over_in = 1'b0, valid_in = 1'b0;
  logic         msb_inv = 1'b0, low_inv = 1'b0, test_n = 1'b1;
  logic         hiz_req = 1'b0, standby = 1'b0;
  logic [W-1:0] dout;
  logic         under_out, over_out, out_en, ready;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] m_d = '0;
  logic         m_u = 0, m_o = 0, m_oe = 0;
  int           m_cnt = 0;

  always #2 clk = ~clk;

  adc_out_fmt uut (
    .clk(clk), .rst_n(rst_n), .code_in(code_in), .under_in(under_in),
    .over_in(over_in), .valid_in(valid_in), .msb_inv(msb_inv),
    .low_inv(low_inv), .test_n(test_n), .hiz_req(hiz_req),
    .standby(standby), .dout(dout), .under_out(under_out),
    .over_out(over_out), .out_en(out_en), .ready(ready)
  );

  function automatic logic [W-1:0] bpat();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i % 2) == 1;
    return r;
  endfunction

  function automatic logic [W-1:0] bfmt(logic [W-1:0] c, logic mi, logic li);
    logic [W-1:0] r = c;
    if (mi) r[W-1] = ~r[W-1];
    for (int i = 0; i < W - 1; i++) if (li) r[i] = ~r[i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(dout == m_d, "R2/R3/R4/R5 dout", dout, m_d);
    chk(under_out == m_u, "R6/R7 under", under_out, m_u);
    chk(over_out == m_o, "R6/R7 over", over_out, m_o);
    chk(out_en == m_oe, "R8 out_en", out_en, m_oe);
    chk(ready == (m_cnt >= 4), "R10 ready", ready, m_cnt >= 4);
  endtask

  task automatic step();
    m_oe = !hiz_req;
    if (!standby && (valid_in || !test_n)) begin
      m_d = bfmt(test_n ? code_in : bpat(), msb_inv, low_inv);
      m_u = test_n && under_in;
      m_o = test_n && over_in;
    end
    if (standby) m_cnt = 0; else if (m_cnt < 4) m_cnt++;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dout == 0 && !under_out && !over_out, "R1 data", dout, 0);
    chk(!out_en && !ready, "R1 oe/ready", {out_en, ready}, 0);
    rst_n = 1'b1;
    standby = 1'b1;
    step();
    chk(!ready, "R1 ready after reset", ready, 0);

    // R5 test pattern under each inversion, valid low
    standby = 1'b0; test_n = 1'b0; valid_in = 1'b0; under_in = 1; over_in = 1;
    for (int k = 0; k < 4; k++) begin
      msb_inv = k[0]; low_inv = k[1];
      step();
      chk(dout == bfmt(10'h2AA, k[0], k[1]), "R5 pattern", dout,
          bfmt(10'h2AA, k[0], k[1]));
      chk(!under_out && !over_out, "R7 flags in test", {under_out, over_out}, 0);
    end

    // R10 ready exactly after the fourth clean edge
    test_n = 1'b1; msb_inv = 0; low_inv = 0;
    standby = 1'b1; step();
    standby = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      step();
      chk(ready == (k == 4), "R10 count", ready, k == 4);
    end
    // R10 restart on pulse mid-count
    standby = 1'b1; step();
    standby = 1'b0; step(); step();
    standby = 1'b1; step();
    chk(!ready, "R9 ready in standby", ready, 0);
    standby = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      step();
      chk(ready == (k == 4), "R10 restart", ready, k == 4);
    end

    // R2 R3 directed values, R6 flags untouched
    valid_in = 1; code_in = 10'h201; under_in = 1; over_in = 0;
    msb_inv = 1; low_inv = 0; step();
    chk(dout == 10'h001, "R2 msb invert", dout, 10'h001);
    chk(under_out && !over_out, "R6 flags unchanged", {under_out, over_out}, 2);
    msb_inv = 0; low_inv = 1; step();
    chk(dout == 10'h3FE, "R3 low invert", dout, 10'h3FE);
    valid_in = 0; code_in = 10'h155; step();
    chk(dout == 10'h3FE, "R4 hold invalid", dout, 10'h3FE);
    standby = 1; valid_in = 1; step();
    chk(dout == 10'h3FE, "R9 hold standby", dout, 10'h3FE);
    standby = 0;
    hiz_req = 1; step();
    chk(!out_en, "R8 float", out_en, 0);
    hiz_req = 0;

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      code_in  = W'($urandom);
      under_in = $urandom % 2;
      over_in  = $urandom % 2;
      valid_in = ($urandom % 4) != 0;
      msb_inv  = $urandom % 2;
      low_inv  = $urandom % 2;
      test_n   = ($urandom % 6) != 0;
      hiz_req  = ($urandom % 8) == 0;
      standby  = ($urandom % 20) == 0;
      step();
    end
    done = 1;
    finish_run();
  end
endmodule